// File: doc/BRIEF.md
# Gated Periodic Scan Trigger Generator

This block sends a slow, periodic trigger to an external analyzer and reports when the analyzer actually starts a scan. The time base is a reference tick of about 1.5 kHz, supplied as a one-cycle enable in the system clock domain. A start request sets a run latch. While that latch is set, the reference ticks feed a fixed prescaler (divide by 15 by default) and then a second divider whose ratio can be loaded (100 by default). Together the two stages give one pulse per second. Each of those pulses fires a one-shot, which holds the trigger output high for a set number of system clocks.

A stop/clear input clears the run latch and both divider counters. When stop and start arrive in the same cycle, stop wins. The second-stage ratio is taken from an input port only while the run latch is clear. A zero setting is ignored, so the ratio is never zero. The analyzer answers a trigger with a sync signal when it begins scanning. That sync passes through a two-flop synchroniser and an edge detector, and comes out as a one-cycle scan-start strobe.

Top module: `gated_scan_trigger`

## Requirements
- R1: After reset `trig_out` and `scan_start` are 0, the run latch is clear, both divider counts are 0 and the second-stage ratio is 100. If `div_sel` stays 0, the first trigger therefore comes after PRE_DIV*100 gated ticks.
- R2: While the run latch is clear, `ref_tick` has no effect and no trigger is produced. `start_req` sets the latch at the next clock edge.
- R3: `stop_clr` clears the run latch and both divider counts at the next edge, and it wins over a `start_req` in the same cycle. After a restart, counting begins again from zero.
- R4: While running, a trigger fires on every PRE_DIV*ratio-th gated tick, counted from the start. `trig_out` goes high in the cycle that follows the clock edge which samples the completing tick.
- R5: Each trigger holds `trig_out` high for exactly PULSE_W consecutive clock cycles.
- R6: The ratio is loaded from `div_sel` on every edge at which the run latch is clear. Changes to `div_sel` while running have no effect on the trigger period.
- R7: A `div_sel` value of 0 is ignored and the previously loaded ratio is kept.
- R8: A rising edge on `ana_sync` produces a one-cycle `scan_start` pulse, visible two cycles after the edge at which `ana_sync` is first sampled high. A held-high sync gives only one pulse.
- R9: A ratio of 1 is supported. A trigger then fires on every prescaler wrap (every PRE_DIV gated ticks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle reference tick enable |
| start_req | input | 1 | Sets the run latch |
| stop_clr | input | 1 | Clears the run latch and the divider counts; wins over start |
| ana_sync | input | 1 | Asynchronous scan-started sync from the analyzer |
| div_sel | input | DIV_W | Ratio for the second stage; loaded while idle, 0 ignored |
| trig_out | output | 1 | Widened trigger to the analyzer |
| scan_start | output | 1 | One-cycle strobe on the rising edge of the synchronised sync |

## Verification
The bench builds the block with PRE_DIV=3 and PULSE_W=5 and keeps the 8-bit ratio port. With these values a full default period of 300 gated ticks can be run, which proves the reset value of the ratio. Ratios of 4, 2 and 1 then give periods short enough to see many triggers and exact pulse widths within a few hundred cycles. Stops in mid-count, simultaneous start and stop, writes to the ratio while running, and zero writes are all placed at cycle-exact points. The expected trigger cycles are derived from a tick count kept in the bench.

// File: rtl/gst_pkg.sv
package gst_pkg;

    localparam int unsigned GST_PRE_DIV_DEF  = 15;
    localparam int unsigned GST_RATIO_DEF    = 100;
    localparam int unsigned GST_PULSE_W_DEF  = 1000;
    localparam int unsigned GST_DIV_W_DEF    = 8;
    localparam int unsigned GST_SYNC_STG_DEF = 2;

    // Enable strobes moving down the divider chain
    typedef struct packed {
        logic gated;
        logic pre;
        logic sec;
    } gst_ticks_t;

    // Next ratio value: a zero request keeps the current ratio
    function automatic logic [GST_DIV_W_DEF-1:0] gst_next_ratio(
        input logic [GST_DIV_W_DEF-1:0] cur,
        input logic [GST_DIV_W_DEF-1:0] req
    );
        return (req == '0) ? cur : req;
    endfunction

endpackage

// File: rtl/gst_mod_counter.sv
module gst_mod_counter #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] modulus,
    output logic [W-1:0] count,
    output logic         wrap
);
    logic at_end;

    assign at_end = (count == modulus - W'(1));
    assign wrap   = en && at_end;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (en) begin
            count <= at_end ? '0 : count + W'(1);
        end
    end
endmodule

// File: rtl/gst_oneshot.sv
module gst_oneshot #(
    parameter int unsigned WIDTH = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse
);
    localparam int unsigned CW = $clog2(WIDTH + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (fire) begin
            remain <= CW'(WIDTH);
        end else if (remain != '0) begin
            remain <= remain - CW'(1);
        end
    end

    assign pulse = (remain != '0);
endmodule

// File: rtl/gst_sync_edge.sv
module gst_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain[0] <= 1'b0;
        end else begin
            chain[0] <= async_in;
        end
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                chain[i] <= 1'b0;
            end else begin
                chain[i] <= chain[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last <= 1'b0;
        end else begin
            last <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] && !last;
endmodule

// File: rtl/gated_scan_trigger.sv
module gated_scan_trigger
    import gst_pkg::*;
#(
    parameter int unsigned PRE_DIV  = GST_PRE_DIV_DEF,
    parameter int unsigned DIV_W    = GST_DIV_W_DEF,
    parameter int unsigned PULSE_W  = GST_PULSE_W_DEF,
    parameter int unsigned SYNC_STG = GST_SYNC_STG_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic             start_req,
    input  logic             stop_clr,
    input  logic             ana_sync,
    input  logic [DIV_W-1:0] div_sel,
    output logic             trig_out,
    output logic             scan_start
);
    localparam int unsigned PW = $clog2(PRE_DIV + 1);

    gst_ticks_t       tk;
    logic             run_q;
    logic [DIV_W-1:0] ratio_q;
    logic [PW-1:0]    pre_cnt;
    logic [DIV_W-1:0] sec_cnt;
    logic             sec_tick;

    // Run latch: clear wins over set
    always_ff @(posedge clk) begin
        if (rst || stop_clr) begin
            run_q <= 1'b0;
        end else if (start_req) begin
            run_q <= 1'b1;
        end
    end

    // Ratio register, open only while idle; zero request keeps value
    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_q <= DIV_W'(GST_RATIO_DEF);
        end else if (!run_q && div_sel != '0) begin
            ratio_q <= div_sel;
        end
    end

    assign tk.gated = ref_tick && run_q;

    gst_mod_counter #(.W(PW)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .clr     (stop_clr),
        .en      (tk.gated),
        .modulus (PW'(PRE_DIV)),
        .count   (pre_cnt),
        .wrap    (tk.pre)
    );

    gst_mod_counter #(.W(DIV_W)) u_sec (
        .clk     (clk),
        .rst     (rst),
        .clr     (stop_clr),
        .en      (tk.pre),
        .modulus (ratio_q),
        .count   (sec_cnt),
        .wrap    (tk.sec)
    );

    assign sec_tick = tk.sec;

    gst_oneshot #(.WIDTH(PULSE_W)) u_shot (
        .clk   (clk),
        .rst   (rst),
        .fire  (sec_tick),
        .pulse (trig_out)
    );

    gst_sync_edge #(.STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ana_sync),
        .rise     (scan_start)
    );
endmodule

// File: rtl/gst_checker.sv
module gst_checker #(
    parameter int unsigned PW      = 4,
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned PULSE_W = 1000
) (
    input logic             clk,
    input logic             rst,
    input logic             stop_clr,
    input logic             trig_out,
    input logic             scan_start,
    input logic             run_q,
    input logic [PW-1:0]    pre_cnt,
    input logic [DIV_W-1:0] ratio_q,
    input logic             sec_tick
);
    int unsigned hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || sec_tick || !trig_out) begin
            hi_cnt <= 0;
        end else begin
            hi_cnt <= hi_cnt + 1;
        end
    end

    a_r2_idle_prescaler_zero: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> pre_cnt == '0);

    a_r3_clear_wins: assert property (@(posedge clk) disable iff (rst)
        stop_clr |=> !run_q);

    a_r4_trig_from_divider: assert property (@(posedge clk) disable iff (rst)
        $rose(trig_out) |-> $past(sec_tick));

    a_r5_width_bound: assert property (@(posedge clk) disable iff (rst)
        trig_out |-> hi_cnt < PULSE_W);

    a_r6_ratio_frozen: assert property (@(posedge clk) disable iff (rst)
        run_q |=> $stable(ratio_q));

    a_r7_ratio_nonzero: assert property (@(posedge clk) disable iff (rst)
        ratio_q != '0);

    a_r8_strobe_single: assert property (@(posedge clk) disable iff (rst)
        scan_start |=> !scan_start);
endmodule

bind gated_scan_trigger gst_checker #(
    .PW      (PW),
    .DIV_W   (DIV_W),
    .PULSE_W (PULSE_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .stop_clr   (stop_clr),
    .trig_out   (trig_out),
    .scan_start (scan_start),
    .run_q      (run_q),
    .pre_cnt    (pre_cnt),
    .ratio_q    (ratio_q),
    .sec_tick   (sec_tick)
);

// File: tb/tb_gated_scan_trigger.sv
module tb_gated_scan_trigger;
    localparam int unsigned PRE   = 3;
    localparam int unsigned PULSE = 5;
    localparam int unsigned DW    = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_tick = 1'b0;
    logic          start_req = 1'b0;
    logic          stop_clr = 1'b0;
    logic          ana_sync = 1'b0;
    logic [DW-1:0] div_sel = '0;
    logic          trig_out;
    logic          scan_start;

    gated_scan_trigger #(
        .PRE_DIV (PRE),
        .DIV_W   (DW),
        .PULSE_W (PULSE)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .ref_tick   (ref_tick),
        .start_req  (start_req),
        .stop_clr   (stop_clr),
        .ana_sync   (ana_sync),
        .div_sel    (div_sel),
        .trig_out   (trig_out),
        .scan_start (scan_start)
    );

    always #5 clk = ~clk;

    int    ncyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string cur_req = "R2";
    int    trig_q[$];
    int    sync_q[$];

    // bench model of the requirements
    bit model_run = 1'b0;
    int model_ratio = 100;
    int gcount = 0;

    always @(posedge clk) ncyc <= ncyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, ncyc);
        end
    endtask

    // Monitor: pops expected trigger and strobe cycles, measures widths
    bit prev_trig = 1'b0;
    int width = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (trig_out && !prev_trig) begin
                if (trig_q.size() == 0) chk(cur_req, ncyc, -1);
                else chk(cur_req, ncyc, trig_q.pop_front());
            end
            if (trig_out) width++;
            if (!trig_out && prev_trig) begin
                chk("R5", width, PULSE);
                width = 0;
            end
            prev_trig = trig_out;
            if (scan_start) begin
                if (sync_q.size() == 0) chk("R8", ncyc, -1);
                else chk("R8", ncyc, sync_q.pop_front());
            end
        end
    end

    task automatic send_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_tick = 1'b1;
            if (model_run) begin
                gcount++;
                if (gcount % (PRE * model_ratio) == 0) trig_q.push_back(ncyc + 1);
            end
            @(negedge clk);
            ref_tick = 1'b0;
        end
    endtask

    task automatic do_start();
        @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        model_run = 1'b1;
    endtask

    task automatic do_stop();
        @(negedge clk);
        stop_clr = 1'b1;
        @(negedge clk);
        stop_clr = 1'b0;
        model_run = 1'b0;
        gcount = 0;
    endtask

    task automatic set_div(input int v);
        @(negedge clk);
        div_sel = DW'(v);
        if (!model_run && v != 0) model_ratio = v;
        @(negedge clk);
    endtask

    task automatic sync_pulse(input int len);
        @(negedge clk);
        ana_sync = 1'b1;
        sync_q.push_back(ncyc + 2);
        repeat (len) @(negedge clk);
        ana_sync = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic drain(input string req);
        repeat (PULSE + 4) @(negedge clk);
        chk(req, trig_q.size(), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", int'(trig_out), 0);
        chk("R1", int'(scan_start), 0);

        // R2: ticks ignored while idle
        cur_req = "R2";
        send_ticks(20);
        chk("R2", int'(trig_out), 0);
        drain("R2");

        // R1 / R7: default ratio 100 kept while div_sel is 0
        cur_req = "R1";
        do_start();
        send_ticks(300);
        drain("R1");

        // R4: ratio 4, several periods with a gap between ticks
        cur_req = "R4";
        do_stop();
        set_div(4);
        do_start();
        send_ticks(30);
        drain("R4");

        // R3: stop in mid-count, restart counts from zero
        cur_req = "R3";
        send_ticks(5);
        do_stop();
        do_start();
        send_ticks(12);
        drain("R3");

        // R6: ratio change while running has no effect
        cur_req = "R6";
        set_div(2);
        send_ticks(24);
        drain("R6");

        // R7: zero request keeps the previously loaded ratio (2)
        cur_req = "R7";
        do_stop();
        set_div(2);
        set_div(0);
        do_start();
        send_ticks(12);
        drain("R7");

        // R3: clear wins over a simultaneous start
        cur_req = "R3";
        do_stop();
        @(negedge clk);
        start_req = 1'b1;
        stop_clr = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        stop_clr = 1'b0;
        send_ticks(12);
        chk("R3", int'(trig_out), 0);
        drain("R3");

        // R9: ratio 1, a trigger on every prescaler wrap
        cur_req = "R9";
        set_div(1);
        do_start();
        send_ticks(9);
        drain("R9");

        // R8: sync strobes, including a long held sync
        sync_pulse(1);
        sync_pulse(10);
        sync_pulse(3);
        repeat (4) @(negedge clk);
        chk("R8", sync_q.size(), 0);
        chk("R8", int'(scan_start), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", ncyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule